// File: doc/BRIEF.md
# Fractional-Carrier PWM Channel

This block is a single pulse-width-modulation channel. Its carrier is a phase accumulator whose value is a pure binary fraction of one period. Every clock a fractional step is added to it, so very low carrier frequencies can be set with fine resolution. The carrier phase is compared against a duty threshold given in tenths of a percent. A mode bit selects between a rising sawtooth, which gives edge-aligned pulses, and a triangle, which gives center-aligned pulses. A synchronization pulse reloads the phase from a start value given in thousandths of a period.

The channel drives two outputs: the main PWM and, when enabled, its complement. Each output's activating edge is held back by a programmable number of clock cycles, so the two never conduct together. A polarity bit applies to both outputs and selects active-high or active-low levels. The duty threshold and the scaled start phase are computed from their per-mille inputs in a registered scaling stage. The carrier-to-pin path is pipelined through compare, dead-time and output registers.

Top module: `pwm_channel`

## Requirements
- R1: Each clock without sync, the phase register advances by `step_i`, modulo 2^PHASE_W. The step is the fraction of a period that elapses per clock, with all PHASE_W bits fractional.
- R2: A clock edge with `sync_i` high loads the phase register with floor(init·2^PHASE_W/1000). Here init is the value `init_i` held one edge earlier (per-mille of a period; values of 1000 or more wrap). While sync stays high, the phase stays at that value.
- R3: With `mode_i`=0 (sawtooth), the main output is active while phase < floor(duty·2^PHASE_W/1000).
- R4: With `mode_i`=1 (triangle), the main output is active while the triangle value is below the same threshold. The triangle value is 2·phase for phase below one half, and 2·(1−phase) otherwise, both in PHASE_W-bit fraction units.
- R5: A duty of 0 keeps the main output inactive. A duty of 1000 or more keeps the raw request active for the whole period.
- R6: With `pol_i`=1 an active level is 1; with `pol_i`=0 it is 0. Reset drives both outputs to 0, and the polarity input takes effect at the output register on the next edge.
- R7: Each output's activating edge is delayed by `dead_i` clock cycles, and its deactivating edge is not delayed. As a result, main and complementary outputs are never active together; a dead time of 0 adds no delay.
- R8: With `comp_en_i`=1, the second output requests activity whenever the main request is inactive. With `comp_en_i`=0, it is held at the inactive level for the current polarity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| duty_i | input | DUTY_W | Duty in tenths of a percent (1000 = full) |
| step_i | input | PHASE_W | Fractional phase increment per clock |
| pol_i | input | 1 | 1 = active-high, 0 = active-low |
| mode_i | input | 1 | 0 = sawtooth, 1 = triangle |
| init_i | input | DUTY_W | Start phase in thousandths of a period |
| sync_i | input | 1 | Reload the phase with the start phase |
| comp_en_i | input | 1 | Enable the complementary output |
| dead_i | input | DT_W | Dead time in clock cycles |
| pwm_o | output | 1 | Main PWM output |
| pwm_n_o | output | 1 | Complementary PWM output |

## Verification
The bench builds the channel with PHASE_W = 16, which brings a carrier period down to a few hundred clocks. With a step of 256, one period is exactly 256 clocks and every phase value on the carrier is a known multiple of 256. Active-cycle counts per period can then be worked out by hand: 64 for a quarter duty on the sawtooth, 127 for half duty on the triangle, and the count minus the dead time for each output. A cycle-by-cycle arithmetic model then sweeps mode, polarity, six duty values including both extremes, two dead times and the complementary enable. This sweep uses a step of 300, so period boundaries fall between phase samples.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic {
    CARRIER_SAW = 1'b0,
    CARRIER_TRI = 1'b1
  } carrier_e;

  localparam int LANE_MAIN = 0;
  localparam int LANE_COMP = 1;
  localparam int LANES     = 2;

endpackage

// File: rtl/pwm_frac_scale.sv
// Registered conversion of a per-mille style integer into a binary fraction:
// q = floor(val * 2^FRAC_W / FULL), truncated to OUT_W bits.
module pwm_frac_scale #(
  parameter int IN_W   = 10,
  parameter int FRAC_W = 42,
  parameter int OUT_W  = 43,
  parameter int FULL   = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] frac_o
);
  localparam int NUM_W = IN_W + FRAC_W + 1;
  localparam logic [NUM_W-1:0] DIVISOR = NUM_W'(FULL);

  logic [NUM_W-1:0] numer;
  logic [OUT_W-1:0] frac_d;

  always_comb begin
    numer  = {1'b0, val_i, {FRAC_W{1'b0}}};
    frac_d = OUT_W'(numer / DIVISOR);
  end

  always_ff @(posedge clk) begin
    if (rst) frac_o <= '0;
    else     frac_o <= frac_d;
  end
endmodule

// File: rtl/pwm_carrier.sv
// Fractional phase accumulator with synchronous reload.
module pwm_carrier #(
  parameter int PHASE_W = 42
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] step_i,
  input  logic               sync_i,
  input  logic [PHASE_W-1:0] start_i,
  output logic [PHASE_W-1:0] phase_o
);
  logic [PHASE_W-1:0] phase_d;

  always_comb begin
    if (sync_i) phase_d = start_i;
    else        phase_d = phase_o + step_i;
  end

  always_ff @(posedge clk) begin
    if (rst) phase_o <= '0;
    else     phase_o <= phase_d;
  end
endmodule

// File: rtl/pwm_compare.sv
// Sawtooth or triangle comparison of the carrier against the duty threshold.
module pwm_compare
  import pwm_pkg::*;
#(
  parameter int PHASE_W = 42
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic [PHASE_W:0]   thresh_i,
  input  logic               full_i,
  input  carrier_e           mode_i,
  output logic               active_o
);
  localparam int CMP_W = PHASE_W + 1;

  logic [CMP_W-1:0] doubled;
  logic [CMP_W-1:0] tri_val;
  logic [CMP_W-1:0] saw_val;
  logic [CMP_W-1:0] cmp_val;
  logic             active_d;

  always_comb begin
    doubled = {phase_i, 1'b0};
    // first half rises as 2p, second half falls as 2(1-p); the latter is
    // the two's complement of 2p in CMP_W bits
    if (phase_i[PHASE_W-1]) tri_val = CMP_W'(0) - doubled;
    else                    tri_val = doubled;
    saw_val = {1'b0, phase_i};
    case (mode_i)
      CARRIER_TRI: cmp_val = tri_val;
      default:     cmp_val = saw_val;
    endcase
    active_d = full_i | (cmp_val < thresh_i);
  end

  always_ff @(posedge clk) begin
    if (rst) active_o <= 1'b0;
    else     active_o <= active_d;
  end
endmodule

// File: rtl/pwm_deadtime.sv
// Delays the activating edge of a request by a cycle count; release is immediate.
module pwm_deadtime #(
  parameter int DT_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_i,
  input  logic [DT_W-1:0] dead_i,
  output logic            drive_o
);
  logic [DT_W-1:0] wait_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_q  <= '0;
      drive_o <= 1'b0;
    end else if (!req_i) begin
      wait_q  <= '0;
      drive_o <= 1'b0;
    end else if (wait_q >= dead_i) begin
      drive_o <= 1'b1;
    end else begin
      wait_q  <= wait_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
#(
  parameter int PHASE_W    = 42,
  parameter int DUTY_W     = 10,
  parameter int DT_W       = 10,
  parameter int FULL_SCALE = 1000
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [DUTY_W-1:0]  duty_i,
  input  logic [PHASE_W-1:0] step_i,
  input  logic               pol_i,
  input  logic               mode_i,
  input  logic [DUTY_W-1:0]  init_i,
  input  logic               sync_i,
  input  logic               comp_en_i,
  input  logic [DT_W-1:0]    dead_i,
  output logic               pwm_o,
  output logic               pwm_n_o
);
  localparam logic [DUTY_W-1:0] FULL_CODE = DUTY_W'(FULL_SCALE);

  logic [PHASE_W:0]   thresh_q;
  logic [PHASE_W-1:0] init_frac;
  logic               full_q;
  logic [PHASE_W-1:0] phase_q;
  logic               active_q;
  carrier_e           mode_sel;
  logic [LANES-1:0]   lane_req;
  logic [LANES-1:0]   lane_drv;

  // duty threshold, one bit wider than the phase so a full period fits
  pwm_frac_scale #(
    .IN_W(DUTY_W), .FRAC_W(PHASE_W), .OUT_W(PHASE_W + 1), .FULL(FULL_SCALE)
  ) u_duty_scale (
    .clk(clk_i), .rst(rst_i), .val_i(duty_i), .frac_o(thresh_q)
  );

  // start phase, wraps modulo one period
  pwm_frac_scale #(
    .IN_W(DUTY_W), .FRAC_W(PHASE_W), .OUT_W(PHASE_W), .FULL(FULL_SCALE)
  ) u_init_scale (
    .clk(clk_i), .rst(rst_i), .val_i(init_i), .frac_o(init_frac)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) full_q <= 1'b0;
    else       full_q <= (duty_i >= FULL_CODE);
  end

  pwm_carrier #(.PHASE_W(PHASE_W)) u_carrier (
    .clk(clk_i), .rst(rst_i), .step_i(step_i), .sync_i(sync_i),
    .start_i(init_frac), .phase_o(phase_q)
  );

  assign mode_sel = carrier_e'(mode_i);

  pwm_compare #(.PHASE_W(PHASE_W)) u_compare (
    .clk(clk_i), .rst(rst_i), .phase_i(phase_q), .thresh_i(thresh_q),
    .full_i(full_q), .mode_i(mode_sel), .active_o(active_q)
  );

  always_comb begin
    lane_req[LANE_MAIN] = active_q;
    lane_req[LANE_COMP] = comp_en_i & ~active_q;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pwm_deadtime #(.DT_W(DT_W)) u_dead (
      .clk(clk_i), .rst(rst_i), .req_i(lane_req[g]), .dead_i(dead_i),
      .drive_o(lane_drv[g])
    );
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pwm_o   <= 1'b0;
      pwm_n_o <= 1'b0;
    end else begin
      pwm_o   <= pol_i ? lane_drv[LANE_MAIN] : ~lane_drv[LANE_MAIN];
      pwm_n_o <= pol_i ? lane_drv[LANE_COMP] : ~lane_drv[LANE_COMP];
    end
  end
endmodule

module pwm_channel_chk #(
  parameter int PHASE_W    = 42,
  parameter int DUTY_W     = 10,
  parameter int FULL_SCALE = 1000
) (
  input logic               clk,
  input logic               rst,
  input logic               sync,
  input logic [PHASE_W-1:0] step,
  input logic [DUTY_W-1:0]  duty,
  input logic [DUTY_W-1:0]  init,
  input logic               comp_en,
  input logic               pol,
  input logic               pwm,
  input logic               pwm_n,
  input logic [PHASE_W-1:0] phase,
  input logic [PHASE_W-1:0] init_sc
);
  localparam int WIDE = PHASE_W + DUTY_W + 12;
  localparam logic [WIDE-1:0] FS = WIDE'(FULL_SCALE);

  logic [2:0]        cyc;
  logic [2:0]        zero_run;
  logic [DUTY_W-1:0] init_d;
  logic [WIDE-1:0]   sc_lo;
  logic [WIDE-1:0]   sc_hi;
  logic [WIDE-1:0]   sc_tgt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc      <= '0;
      zero_run <= '0;
      init_d   <= '0;
    end else begin
      init_d <= init;
      if (cyc != 3'd7) cyc <= cyc + 1'b1;
      if (duty != '0) zero_run <= '0;
      else if (zero_run != 3'd7) zero_run <= zero_run + 1'b1;
    end
  end

  always_comb begin
    sc_lo  = WIDE'(init_sc) * FS;
    sc_hi  = (WIDE'(init_sc) + WIDE'(1)) * FS;
    sc_tgt = WIDE'(init_d) << PHASE_W;
  end

  // R1
  step_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 3'd1 && !sync) |=> (phase == PHASE_W'($past(phase) + $past(step))));

  // R2
  sync_load_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 3'd1 && sync) |=> (phase == $past(init_sc)));

  // R2
  init_scale_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 3'd2 && init_d < DUTY_W'(FULL_SCALE)) |-> (sc_lo <= sc_tgt && sc_hi > sc_tgt));

  // R5
  zero_duty_chk: assert property (@(posedge clk) disable iff (rst)
    (zero_run >= 3'd4 && cyc >= 3'd5) |-> (pwm == !$past(pol)));

  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 3'd2) |-> !((pwm == $past(pol)) && (pwm_n == $past(pol))));

  // R8
  comp_off_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 3'd2 && !comp_en) |=> ##1 (pwm_n == !$past(pol)));
endmodule

bind pwm_channel pwm_channel_chk #(
  .PHASE_W(PHASE_W), .DUTY_W(DUTY_W), .FULL_SCALE(FULL_SCALE)
) u_chk (
  .clk(clk_i), .rst(rst_i), .sync(sync_i), .step(step_i), .duty(duty_i),
  .init(init_i), .comp_en(comp_en_i), .pol(pol_i), .pwm(pwm_o),
  .pwm_n(pwm_n_o), .phase(phase_q), .init_sc(init_frac)
);

// File: tb/tb_pwm_channel.sv
module tb_pwm_channel;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [9:0]    duty = '0;
  logic [PW-1:0] step = '0;
  logic          pol = 1'b1;
  logic          mode = 1'b0;
  logic [9:0]    init = '0;
  logic          sync = 1'b0;
  logic          comp_en = 1'b0;
  logic [9:0]    dead = '0;
  logic          pwm_o, pwm_n_o;

  int  total = 0;
  int  fails = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  pwm_channel #(.PHASE_W(PW), .DUTY_W(10), .DT_W(10), .FULL_SCALE(1000)) dut (
    .clk_i(clk), .rst_i(rst), .duty_i(duty), .step_i(step), .pol_i(pol),
    .mode_i(mode), .init_i(init), .sync_i(sync), .comp_en_i(comp_en),
    .dead_i(dead), .pwm_o(pwm_o), .pwm_n_o(pwm_n_o)
  );

  // arithmetic reference built from the requirements
  logic [PW-1:0] m_ph, m_isc;
  logic [PW:0]   m_thr;
  logic          m_full, m_act, m_dm, m_dc, m_out, m_outn, creq;
  int            m_cm, m_cc;

  function automatic logic ref_active(logic [PW-1:0] p, logic [PW:0] thr, logic full, logic md);
    longint v;
    if (full) return 1'b1;
    if (md == 1'b0)        v = longint'(p);
    else if (p < 16'h8000) v = 2 * longint'(p);
    else                   v = 2 * (65536 - longint'(p));
    return v < longint'(thr);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ph = '0; m_isc = '0; m_thr = '0; m_full = 1'b0; m_act = 1'b0;
      m_dm = 1'b0; m_dc = 1'b0; m_out = 1'b0; m_outn = 1'b0; m_cm = 0; m_cc = 0;
    end else begin
      m_out  = pol ? m_dm : !m_dm;
      m_outn = pol ? m_dc : !m_dc;
      if (!m_act) begin m_dm = 1'b0; m_cm = 0; end
      else if (m_cm >= int'(dead)) m_dm = 1'b1;
      else m_cm++;
      creq = comp_en && !m_act;
      if (!creq) begin m_dc = 1'b0; m_cc = 0; end
      else if (m_cc >= int'(dead)) m_dc = 1'b1;
      else m_cc++;
      m_act  = ref_active(m_ph, m_thr, m_full, mode);
      m_ph   = sync ? m_isc : PW'(m_ph + step);
      m_isc  = PW'((longint'(init) * 65536) / 1000);
      m_thr  = (PW+1)'((longint'(duty) * 65536) / 1000);
      m_full = (duty >= 10'd1000);
    end
  end

  task automatic check(input bit ok, input string req, input int got, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic run_model(input int n, input string req);
    repeat (n) begin
      @(posedge clk); #1;
      check(pwm_o === m_out, req, int'(pwm_o), int'(m_out));
      check(pwm_n_o === m_outn, req, int'(pwm_n_o), int'(m_outn));
    end
  endtask

  task automatic count_win(input int n, output int a, output int b);
    a = 0; b = 0;
    repeat (n) begin
      @(posedge clk); #1;
      a += int'(pwm_o);
      b += int'(pwm_n_o);
    end
  endtask

  task automatic setup(input logic md, input logic pl, input int du, input int dt, input logic ce, input int st);
    mode = md; pol = pl; duty = 10'(du); dead = 10'(dt); comp_en = ce; step = PW'(st);
  endtask

  initial begin
    int a, b;
    int dl[6] = '{0, 1, 333, 500, 999, 1000};
    repeat (5) @(posedge clk);
    #1;
    // R6: reset levels
    check(pwm_o === 1'b0, "R6 reset main", int'(pwm_o), 0);
    check(pwm_n_o === 1'b0, "R6 reset comp", int'(pwm_n_o), 0);
    rst = 1'b0;

    // R3 quarter duty on sawtooth, 256-clock period
    setup(1'b0, 1'b1, 250, 0, 1'b1, 256);
    run_model(600, "R3 model");
    count_win(256, a, b);
    check(a == 64, "R3 saw count", a, 64);
    check(b == 192, "R8 comp count", b, 192);

    // R7 dead time of 5
    dead = 10'd5;
    run_model(300, "R7 model");
    count_win(256, a, b);
    check(a == 59, "R7 main count", a, 59);
    check(b == 187, "R7 comp count", b, 187);

    // R4 triangle half duty
    setup(1'b1, 1'b1, 500, 0, 1'b1, 256);
    run_model(300, "R4 model");
    count_win(256, a, b);
    check(a == 127, "R4 tri count", a, 127);

    // R1 doubled step halves the period
    setup(1'b0, 1'b1, 500, 0, 1'b0, 512);
    run_model(300, "R1 model");
    count_win(256, a, b);
    check(a == 128, "R1 step count", a, 128);
    check(b == 0, "R8 comp disabled", b, 0);

    // R6 active-low
    setup(1'b0, 1'b0, 250, 0, 1'b1, 256);
    run_model(300, "R6 model");
    count_win(256, a, b);
    check(a == 192, "R6 low main count", a, 192);
    check(b == 64, "R6 low comp count", b, 64);

    // R5 extremes
    setup(1'b0, 1'b1, 0, 0, 1'b1, 256);
    run_model(300, "R5 model");
    count_win(256, a, b);
    check(a == 0, "R5 zero duty", a, 0);
    setup(1'b1, 1'b1, 1023, 0, 1'b1, 256);
    run_model(300, "R5 model");
    count_win(256, a, b);
    check(a == 256, "R5 full duty main", a, 256);
    check(b == 0, "R5 full duty comp", b, 0);

    // R2 sync held: phase frozen at scaled start
    setup(1'b0, 1'b1, 10, 0, 1'b0, 300);
    init = 10'd0; sync = 1'b1;
    run_model(20, "R2 model");
    count_win(100, a, b);
    check(a == 100, "R2 hold at zero", a, 100);
    duty = 10'd499; init = 10'd500;
    run_model(20, "R2 model");
    count_win(100, a, b);
    check(a == 0, "R2 hold at half", a, 0);
    // R2 single pulses at different start points
    sync = 1'b0; duty = 10'd400;
    for (int k = 0; k < 3; k++) begin
      init = (k == 0) ? 10'd0 : (k == 1) ? 10'd999 : 10'd250;
      run_model(40, "R2 model");
      sync = 1'b1;
      run_model(1, "R2 model");
      sync = 1'b0;
      run_model(150, "R2 model");
    end

    // sweep of mode, polarity, duty, dead time, complementary enable
    for (int md = 0; md < 2; md++)
      for (int pl = 0; pl < 2; pl++)
        for (int di = 0; di < 6; di++)
          for (int dt = 0; dt < 2; dt++)
            for (int ce = 0; ce < 2; ce++) begin
              setup(1'(md), 1'(pl), dl[di], dt * 7, 1'(ce), 300);
              run_model(200, md ? "R4/R6/R7/R8 sweep" : "R3/R6/R7/R8 sweep");
            end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule